// File: doc/BRIEF.md
# SPI Register Slave with Variable-Length Reads

This block is an SPI slave (clock idle low, data sampled on the rising SCLK edge, most significant bit first) that puts a small byte-wide register file, three 24-bit measurement values and a snapshot of up to three counters on one serial port. Every transfer opens with an instruction byte that carries the opcode, followed by an address byte. A write then stores any number of data bytes at consecutive addresses. A read shifts out a frame whose length depends on the address and, for counter data, on a partition field held in register 0.

SCLK, chip select and MOSI are brought into the system clock domain through two-flop synchronizers. SCLK must therefore run several times slower than `clk_i`. Counter values, measurement values and the two active-low status flags arrive as input ports. All read data is captured into a shadow shift register at the moment the address byte completes.

Top module: `spi_cnt_slave`

## Requirements
- R1: Bits 7:6 of the instruction byte select the operation: 2'b10 is write, 2'b11 is read. Any other value makes the slave ignore the rest of the transfer: no register changes and MISO stays 0.
- R2: In a write, each completed data byte is stored at the current address, and the address then increments by 1 for as long as chip select stays low. Addresses 0x00 to NREGS-1 (8 by default) are writable. A write to any other address has no effect.
- R3: After reset all registers read as 0x00 and MISO is 0.
- R4: A read of a register address returns that register's 8 bits first and zeros after them. A read of an address that is neither a register nor a data address returns all zeros.
- R5: A read of 0x0A, 0x0C or 0x0E returns measurement value A, B or C respectively. The frame is the 24-bit value (bit 23 first), then err_ni, then warn_ni, then zeros.
- R6: A read of 0x08 returns counter data laid out by cfg = register 0 bits 2:0. The highest counter is sent first, each counter MSB first. The encodings are: 000 c0[23:0]; 001 c1[23:0],c0[23:0]; 010 c0[47:0]; 011 c0[15:0]; 100 c0[31:0]; 101 c1[15:0],c0[31:0]; 110 c1[15:0],c0[15:0]; 111 c2[15:0],c1[15:0],c0[15:0].
- R7: In a counter read, err_ni and then warn_ni follow the last counter bit directly. Every bit after them, up to a whole number of bytes and beyond, reads 0.
- R8: Read data is captured when the address byte completes. Later changes on the data inputs do not alter the frame being shifted out.
- R9: Raising chip select ends the transfer at once. A partially received byte is discarded, and MISO returns to 0 while chip select is high.
- R10: MISO changes only after an SCLK falling edge or when chip select goes high. The bit counter advances by one for each rising SCLK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI serial clock, idle low |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| cnt0_i | input | 48 | Counter 0 value |
| cnt1_i | input | 24 | Counter 1 value |
| cnt2_i | input | 16 | Counter 2 value |
| meas_a_i | input | 24 | Measurement value read at 0x0A |
| meas_b_i | input | 24 | Measurement value read at 0x0C |
| meas_c_i | input | 24 | Measurement value read at 0x0E |
| err_ni | input | 1 | Error flag, active low |
| warn_ni | input | 1 | Warning flag, active low |

## Verification
All eight partition encodings are swept twice, with two different counter patterns and opposite status values. This separates per-encoding ordering, truncation, status placement and padding errors. Each measurement address is read with all four status combinations, so a swapped flag or a wrong address decode shows up. A multi-byte write, a write cut off after a partial byte, an invalid opcode and an out-of-range write tell increment, discard and ignore behaviour apart. A read during which the inputs change shows whether the frame was captured early.

// File: rtl/spi_cnt_pkg.sv
package spi_cnt_pkg;
  localparam int CNT0_W  = 48;
  localparam int CNT1_W  = 24;
  localparam int CNT2_W  = 16;
  localparam int MEAS_W  = 24;
  localparam int STAT_W  = 2;
  localparam int FRAME_W = ((CNT0_W + STAT_W + 7) / 8) * 8;

  localparam logic [1:0] OP_WR = 2'b10;
  localparam logic [1:0] OP_RD = 2'b11;

  localparam logic [7:0] ADDR_CNT = 8'h08;
  localparam logic [7:0] ADDR_MA  = 8'h0A;
  localparam logic [7:0] ADDR_MB  = 8'h0C;
  localparam logic [7:0] ADDR_MC  = 8'h0E;

  typedef enum logic [2:0] {
    PH_CMD, PH_ADDR, PH_WR, PH_RD, PH_SKIP
  } phase_e;

  function automatic int unsigned cnt_len(input logic [2:0] cfg);
    case (cfg)
      3'b000:  return 24;
      3'b011:  return 16;
      3'b100,
      3'b110:  return 32;
      default: return 48;
    endcase
  endfunction
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter logic RST_VAL = 1'b0,
  parameter int   STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {(STAGES+1){RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-1:0], d_i};
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o = ~pipe_q[STAGES-1] &  pipe_q[STAGES];
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
  parameter int NREGS = 8,
  parameter int AW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o,
  output logic          rhit_o,
  output logic [2:0]    cfg_o
);
  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [7:0] regs_q [NREGS];
  logic       wsel;

  assign wsel   = we_i && (waddr_i < AW'(NREGS));
  assign rhit_o = raddr_i < AW'(NREGS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (wsel) begin
      regs_q[waddr_i[IW-1:0]] <= wdata_i;
    end
  end

  assign rdata_o = rhit_o ? regs_q[raddr_i[IW-1:0]] : 8'h00;
  assign cfg_o   = regs_q[0][2:0];
endmodule

// File: rtl/spi_read_frame.sv
module spi_read_frame
  import spi_cnt_pkg::*;
(
  input  logic [7:0]         addr_i,
  input  logic [2:0]         cfg_i,
  input  logic [CNT0_W-1:0]  cnt0_i,
  input  logic [CNT1_W-1:0]  cnt1_i,
  input  logic [CNT2_W-1:0]  cnt2_i,
  input  logic [MEAS_W-1:0]  meas_a_i,
  input  logic [MEAS_W-1:0]  meas_b_i,
  input  logic [MEAS_W-1:0]  meas_c_i,
  input  logic               err_ni,
  input  logic               warn_ni,
  input  logic [7:0]         reg_i,
  input  logic               reg_hit_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [CNT0_W-1:0]  cnt_data;
  logic [FRAME_W-1:0] cnt_frame;
  logic [MEAS_W-1:0]  meas_sel;
  int unsigned        stat_pos;

  // counter data left-aligned, highest counter first
  always_comb begin
    case (cfg_i)
      3'b000:  cnt_data = {cnt0_i[23:0], 24'h0};
      3'b001:  cnt_data = {cnt1_i[23:0], cnt0_i[23:0]};
      3'b010:  cnt_data = cnt0_i;
      3'b011:  cnt_data = {cnt0_i[15:0], 32'h0};
      3'b100:  cnt_data = {cnt0_i[31:0], 16'h0};
      3'b101:  cnt_data = {cnt1_i[15:0], cnt0_i[31:0]};
      3'b110:  cnt_data = {cnt1_i[15:0], cnt0_i[15:0], 16'h0};
      default: cnt_data = {cnt2_i, cnt1_i[15:0], cnt0_i[15:0]};
    endcase
    stat_pos  = FRAME_W - STAT_W - cnt_len(cfg_i);
    cnt_frame = {cnt_data, {(FRAME_W-CNT0_W){1'b0}}}
              | (FRAME_W'({err_ni, warn_ni}) << stat_pos);
  end

  always_comb begin
    case (addr_i)
      ADDR_MA: meas_sel = meas_a_i;
      ADDR_MB: meas_sel = meas_b_i;
      default: meas_sel = meas_c_i;
    endcase
  end

  always_comb begin
    if (addr_i == ADDR_CNT)
      frame_o = cnt_frame;
    else if (addr_i == ADDR_MA || addr_i == ADDR_MB || addr_i == ADDR_MC)
      frame_o = {meas_sel, err_ni, warn_ni, {(FRAME_W-MEAS_W-STAT_W){1'b0}}};
    else if (reg_hit_i)
      frame_o = {reg_i, {(FRAME_W-8){1'b0}}};
    else
      frame_o = '0;
  end
endmodule

// File: rtl/spi_cnt_slave.sv
module spi_cnt_slave
  import spi_cnt_pkg::*;
#(
  parameter int NREGS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic [CNT0_W-1:0] cnt0_i,
  input  logic [CNT1_W-1:0] cnt1_i,
  input  logic [CNT2_W-1:0] cnt2_i,
  input  logic [MEAS_W-1:0] meas_a_i,
  input  logic [MEAS_W-1:0] meas_b_i,
  input  logic [MEAS_W-1:0] meas_c_i,
  input  logic              err_ni,
  input  logic              warn_ni
);
  logic sclk_s, sclk_rise, sclk_fall;
  logic cs_high, cs_rise_unused, cs_fall_unused;
  logic mosi_s, mosi_rise_unused, mosi_fall_unused;

  spi_edge_sync #(.RST_VAL(1'b0)) u_sclk (
    .clk_i, .rst_ni, .d_i(sclk_i),
    .lvl_o(sclk_s), .rise_o(sclk_rise), .fall_o(sclk_fall));
  spi_edge_sync #(.RST_VAL(1'b1)) u_cs (
    .clk_i, .rst_ni, .d_i(cs_ni),
    .lvl_o(cs_high), .rise_o(cs_rise_unused), .fall_o(cs_fall_unused));
  spi_edge_sync #(.RST_VAL(1'b0)) u_mosi (
    .clk_i, .rst_ni, .d_i(mosi_i),
    .lvl_o(mosi_s), .rise_o(mosi_rise_unused), .fall_o(mosi_fall_unused));

  phase_e             phase_q;
  logic [2:0]         bit_cnt;
  logic [6:0]         sh_in;
  logic [1:0]         op_q;
  logic [7:0]         addr_q;
  logic [FRAME_W-1:0] shadow_q;
  logic               miso_q;
  logic [7:0]         byte_val;
  logic               byte_done;
  logic               reg_we;
  logic               phase_idle;
  logic [7:0]         reg_rd;
  logic               reg_hit;
  logic [2:0]         cfg;
  logic [FRAME_W-1:0] frame;

  assign byte_val   = {sh_in, mosi_s};
  assign byte_done  = !cs_high && sclk_rise && (bit_cnt == 3'd7);
  assign reg_we     = byte_done && (phase_q == PH_WR);
  assign phase_idle = (phase_q == PH_CMD);

  spi_reg_bank #(.NREGS(NREGS), .AW(8)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we), .waddr_i(addr_q), .wdata_i(byte_val),
    .raddr_i(byte_val), .rdata_o(reg_rd), .rhit_o(reg_hit), .cfg_o(cfg));

  spi_read_frame u_frame (
    .addr_i(byte_val), .cfg_i(cfg),
    .cnt0_i, .cnt1_i, .cnt2_i,
    .meas_a_i, .meas_b_i, .meas_c_i,
    .err_ni, .warn_ni,
    .reg_i(reg_rd), .reg_hit_i(reg_hit),
    .frame_o(frame));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_CMD;
      bit_cnt  <= '0;
      sh_in    <= '0;
      op_q     <= '0;
      addr_q   <= '0;
      shadow_q <= '0;
      miso_q   <= 1'b0;
    end else if (cs_high) begin
      phase_q  <= PH_CMD;
      bit_cnt  <= '0;
      sh_in    <= '0;
      shadow_q <= '0;
      miso_q   <= 1'b0;
    end else begin
      if (sclk_rise) begin
        sh_in   <= byte_val[6:0];
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (byte_done) begin
        case (phase_q)
          PH_CMD: begin
            op_q    <= byte_val[7:6];
            phase_q <= (byte_val[7:6] == OP_WR || byte_val[7:6] == OP_RD)
                       ? PH_ADDR : PH_SKIP;
          end
          PH_ADDR: begin
            addr_q <= byte_val;
            if (op_q == OP_RD) begin
              phase_q  <= PH_RD;
              shadow_q <= frame;
            end else begin
              phase_q  <= PH_WR;
            end
          end
          PH_WR:   addr_q <= addr_q + 8'd1;
          default: ;
        endcase
      end
      if (sclk_fall && phase_q == PH_RD) begin
        miso_q   <= shadow_q[FRAME_W-1];
        shadow_q <= {shadow_q[FRAME_W-2:0], 1'b0};
      end
    end
  end

  assign miso_o = miso_q;
endmodule

// File: rtl/spi_cnt_slave_chk.sv
module spi_cnt_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_high_i,
  input logic       sclk_rise_i,
  input logic       sclk_fall_i,
  input logic       we_i,
  input logic [7:0] addr_i,
  input logic [2:0] cfg_i,
  input logic [2:0] bit_cnt_i,
  input logic       idle_i,
  input logic       miso_i
);
  // R2: address steps by one after each stored byte
  a_r2_addr_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> addr_i == $past(addr_i) + 8'd1);

  // R2: configuration only changes through a write
  a_r2_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(cfg_i));

  // R9: chip select high returns to idle
  a_r9_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_high_i |=> (bit_cnt_i == 3'd0) && idle_i);

  // R9: MISO quiet while deselected
  a_r9_miso_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_high_i |=> !miso_i);

  // R10: MISO moves only on falling SCLK
  a_r10_miso_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sclk_fall_i && !cs_high_i) |=> $stable(miso_i));

  // R10: one bit per rising edge
  a_r10_bit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise_i && !cs_high_i) |=> bit_cnt_i == $past(bit_cnt_i) + 3'd1);
endmodule

bind spi_cnt_slave spi_cnt_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_high_i  (cs_high),
  .sclk_rise_i(sclk_rise),
  .sclk_fall_i(sclk_fall),
  .we_i       (reg_we),
  .addr_i     (addr_q),
  .cfg_i      (cfg),
  .bit_cnt_i  (bit_cnt),
  .idle_i     (phase_idle),
  .miso_i     (miso_o)
);

// File: tb/spi_cnt_slave_test.sv
module spi_cnt_slave_test;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso;
  logic [47:0] cnt0 = '0;
  logic [23:0] cnt1 = '0;
  logic [15:0] cnt2 = '0;
  logic [23:0] ma = '0, mb = '0, mc = '0;
  logic        err_n = 1'b1, warn_n = 1'b1;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_cnt_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n),
    .mosi_i(mosi), .miso_o(miso),
    .cnt0_i(cnt0), .cnt1_i(cnt1), .cnt2_i(cnt2),
    .meas_a_i(ma), .meas_b_i(mb), .meas_c_i(mc),
    .err_ni(err_n), .warn_ni(warn_n));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic spi_bits(input int n, input logic [127:0] tx, output logic [127:0] rx);
    rx = '0;
    for (int i = 0; i < n; i++) begin
      mosi = tx[n-1-i];
      repeat (H) @(negedge clk);
      rx = {rx[126:0], miso};
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic wr_bytes(input logic [7:0] addr, input int n, input logic [31:0] data);
    logic [127:0] rx;
    cs_begin();
    spi_bits(16, {112'h0, 8'h80, addr}, rx);
    for (int i = 0; i < n; i++) spi_bits(8, {120'h0, data[31-8*i -: 8]}, rx);
    cs_end();
  endtask

  task automatic rd_frame(input logic [7:0] addr, output logic [55:0] f);
    logic [127:0] rx;
    cs_begin();
    spi_bits(72, {56'h0, 8'hC0, addr, 56'h0}, rx);
    cs_end();
    f = rx[55:0];
  endtask

  function automatic logic [55:0] exp_cnt(input logic [2:0] cfg, input logic [47:0] c0,
      input logic [23:0] c1, input logic [15:0] c2, input logic e, input logic w);
    int w0, w1, w2, len;
    logic [63:0] acc;
    case (cfg)
      3'd0: begin w0 = 24; w1 = 0;  w2 = 0;  end
      3'd1: begin w0 = 24; w1 = 24; w2 = 0;  end
      3'd2: begin w0 = 48; w1 = 0;  w2 = 0;  end
      3'd3: begin w0 = 16; w1 = 0;  w2 = 0;  end
      3'd4: begin w0 = 32; w1 = 0;  w2 = 0;  end
      3'd5: begin w0 = 32; w1 = 16; w2 = 0;  end
      3'd6: begin w0 = 16; w1 = 16; w2 = 0;  end
      default: begin w0 = 16; w1 = 16; w2 = 16; end
    endcase
    len = w0 + w1 + w2;
    acc = 64'(c2) & ((64'd1 << w2) - 1);
    acc = (acc << w1) | (64'(c1) & ((64'd1 << w1) - 1));
    acc = (acc << w0) | (64'(c0) & ((64'd1 << w0) - 1));
    acc = (acc << 2) | {62'h0, e, w};
    acc = acc << (54 - len);
    return acc[55:0];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [55:0]  f, fexp;
    logic [127:0] rx;
    logic [47:0]  c0s;
    logic         es;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3: reset state
    chk("R3 miso", {63'h0, miso}, 64'h0);
    rd_frame(8'h00, f);
    chk("R3 reg0", {8'h0, f}, 64'h0);
    rd_frame(8'h05, f);
    chk("R3 reg5", {8'h0, f}, 64'h0);

    // R2: multi-byte write with increment
    wr_bytes(8'h00, 4, 32'h05_11_22_33);
    for (int a = 0; a < 4; a++) begin
      rd_frame(8'(a), f);
      chk("R2 R4 incr write", {8'h0, f}, {8'h0, 8'(a == 0 ? 8'h05 : 8'h11 * a), 48'h0});
    end
    wr_bytes(8'h07, 2, 32'h77_99_00_00);
    rd_frame(8'h07, f);
    chk("R2 last reg", {8'h0, f}, {8'h0, 8'h77, 48'h0});
    wr_bytes(8'h10, 1, 32'hAB_00_00_00);
    rd_frame(8'h10, f);
    chk("R2 R4 unmapped", {8'h0, f}, 64'h0);

    // R9: abort mid byte
    cs_begin();
    spi_bits(24, {104'h0, 8'h80, 8'h02, 8'h5A}, rx);
    spi_bits(4, 128'hF, rx);
    cs_end();
    rd_frame(8'h02, f);
    chk("R9 full byte kept", {8'h0, f}, {8'h0, 8'h5A, 48'h0});
    rd_frame(8'h03, f);
    chk("R9 partial byte dropped", {8'h0, f}, {8'h0, 8'h33, 48'h0});
    chk("R9 miso idle", {63'h0, miso}, 64'h0);

    // R1: invalid opcode ignored
    cs_begin();
    spi_bits(32, {96'h0, 8'h40, 8'h01, 8'hEE, 8'hEE}, rx);
    cs_end();
    chk("R1 miso zero", rx[63:0], 64'h0);
    rd_frame(8'h01, f);
    chk("R1 no write", {8'h0, f}, {8'h0, 8'h11, 48'h0});

    // R6 R7: sweep all partitions with two patterns
    for (int p = 0; p < 2; p++) begin
      cnt0 = p ? 48'hA5C3_1E2D_7F09 : 48'h0123_4567_89AB;
      cnt1 = p ? 24'h3C_96E1 : 24'hFE_DCBA;
      cnt2 = p ? 16'h5AA5 : 16'hC0DE;
      err_n  = p[0];
      warn_n = ~p[0];
      for (int c = 0; c < 8; c++) begin
        wr_bytes(8'h00, 1, {5'h0, 3'(c), 24'h0});
        rd_frame(8'h08, f);
        fexp = exp_cnt(3'(c), cnt0, cnt1, cnt2, err_n, warn_n);
        chk($sformatf("R6 R7 cfg=%0d p=%0d", c, p), {8'h0, f}, {8'h0, fexp});
      end
    end

    // R5: measurement reads, all status combinations
    ma = 24'h12_3456; mb = 24'hAB_CDEF; mc = 24'h80_0001;
    for (int s = 0; s < 4; s++) begin
      err_n  = s[1];
      warn_n = s[0];
      rd_frame(8'h0A, f);
      chk("R5 meas A", {8'h0, f}, {8'h0, ma, err_n, warn_n, 30'h0});
      rd_frame(8'h0C, f);
      chk("R5 meas B", {8'h0, f}, {8'h0, mb, err_n, warn_n, 30'h0});
      rd_frame(8'h0E, f);
      chk("R5 meas C", {8'h0, f}, {8'h0, mc, err_n, warn_n, 30'h0});
    end

    // R8: inputs change during shift-out
    wr_bytes(8'h00, 1, 32'h02_00_00_00);
    cnt0 = 48'hF0E1_D2C3_B4A5;
    err_n = 1'b0; warn_n = 1'b1;
    c0s = cnt0; es = err_n;
    fork
      rd_frame(8'h08, f);
      begin
        repeat (H + 16*2*H + 4*2*H) @(negedge clk);
        cnt0 = ~cnt0;
        err_n = ~err_n;
      end
    join
    chk("R8 snapshot", {8'h0, f}, {8'h0, exp_cnt(3'd2, c0s, cnt1, cnt2, es, 1'b1)});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule